// File: doc/BRIEF.md
# Data Island Packet Assembler

This block sits behind the TERC4 decoders of a TMDS receiver. While a data island is in progress, it takes one decoded 4-bit nibble from each of the three channels on every beat. From those nibbles it recovers the two sync levels, collects the header bit stream and the body bit streams of each packet, and presents every finished packet as a single wide word. BCH checking is left to a later stage, so the parity bits inside the header and the subpackets are passed on exactly as they arrive.

Beats enter through a valid/ready stream: a beat counts only in a cycle where `in_valid` and `in_ready` are both high. Finished packets leave through a second valid/ready stream that has one register stage. When that stage holds a packet the consumer has not yet taken, `in_ready` drops, and upstream must hold its current beat until `in_ready` rises again. A pulse at the close of each island reports how many whole packets the island held, and flags any island whose packet count or alignment is illegal.

Top module: `island_pkt_asm`

## Requirements
- R1: After reset, `pkt_valid`, `isl_done`, `isl_err`, `hsync` and `vsync` are 0 and `in_ready` is 1.
- R2: `hsync` and `vsync` take the values of `ch0` bit 0 and `ch0` bit 1 in the cycle after any accepted beat that has `island_act` high, whether or not `guard` is set. In every other cycle they hold their value.
- R3: `pkt_hdr` bit i is `ch0` bit 2 of the i-th data beat of the packet, counting from 0, so the header enters LSB first. Bits 31:24 carry the parity bits unchanged.
- R4: Subpacket k sits at `pkt_body[64k+63:64k]`. Its bit 2i is `ch1` bit k and its bit 2i+1 is `ch2` bit k, both taken from data beat i.
- R5: A data beat is an accepted beat with `island_act` high and `guard` low. `pkt_valid` rises in the cycle after the 32nd data beat of a packet is accepted. Guard beats do not advance the packet.
- R6: While `pkt_valid` is high and `pkt_ready` is low, `in_ready` is low and `pkt_valid`, `pkt_hdr` and `pkt_body` stay unchanged. A cycle with `in_valid` low has no effect.
- R7: `ch0` bit 3 has no effect on any output.
- R8: On the first accepted beat with `island_act` low after one or more island beats, `isl_done` pulses high for one cycle. In that cycle `isl_pkts` gives the number of whole packets the island held.
- R9: An island that held no whole packet reports `isl_err` = 1 with its `isl_done` pulse.
- R10: An island that held more than 18 packets reports `isl_err` = 1, with `isl_pkts` saturated at 19. Every packet in such an island is still delivered.
- R11: An island that ends partway through a packet reports `isl_err` = 1. The bits of the partial packet are dropped, and the next island starts at data beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded beat is present |
| in_ready | output | 1 | The block accepts the beat this cycle |
| island_act | input | 1 | The beat belongs to a data island |
| guard | input | 1 | The beat is a guard-band character |
| ch0 | input | 4 | Channel 0 nibble: sync, header bit, unused bit 3 |
| ch1 | input | 4 | Channel 1 nibble: even body bits |
| ch2 | input | 4 | Channel 2 nibble: odd body bits |
| pkt_valid | output | 1 | A finished packet is presented |
| pkt_ready | input | 1 | The consumer takes the packet |
| pkt_hdr | output | 32 | Header with parity bits |
| pkt_body | output | 256 | Four 64-bit subpackets |
| hsync | output | 1 | Recovered horizontal sync |
| vsync | output | 1 | Recovered vertical sync |
| isl_done | output | 1 | One-cycle pulse when an island closes |
| isl_pkts | output | 5 | Whole packets in the closed island |
| isl_err | output | 1 | The closed island had an illegal count or alignment |

## Verification
The hardest condition to reach from the ports is a consumer stall that starts just as the last beat of the next packet arrives. The same pressure is needed deep inside an island that runs past 18 packets. The bench drives `pkt_ready` from a pseudo-random sequence and adds gaps on `in_valid`, all during islands of 18 and 20 packets. This holds the output register through many stalled beats. Separate islands with no packets, and with a packet cut short, test the end-of-island verdict and confirm that the following island starts cleanly aligned.

// File: rtl/isl_pkg.sv
package isl_pkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic             hs;
    logic             vs;
    logic             hdr_bit;
    logic [NIB_W-1:0] even_bits;
    logic [NIB_W-1:0] odd_bits;
  } isl_beat_t;
endpackage

// File: rtl/isl_beat_split.sv
module isl_beat_split
  import isl_pkg::*;
(
  input  logic [NIB_W-1:0] ch0,
  input  logic [NIB_W-1:0] ch1,
  input  logic [NIB_W-1:0] ch2,
  output isl_beat_t        beat
);
  logic unused_ch0_top;

  assign unused_ch0_top = ch0[3];

  always_comb begin
    beat.hs        = ch0[0];
    beat.vs        = ch0[1];
    beat.hdr_bit   = ch0[2];
    beat.even_bits = ch1;
    beat.odd_bits  = ch2;
  end
endmodule

// File: rtl/isl_sync_rec.sv
module isl_sync_rec (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic hs_in,
  input  logic vs_in,
  output logic hsync,
  output logic vsync
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else if (upd) begin
      hsync <= hs_in;
      vsync <= vs_in;
    end
  end
endmodule

// File: rtl/isl_lane_map.sv
module isl_lane_map #(
  parameter int PKT_BEATS = 32,
  parameter int SUBS      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift,
  input  logic                        hdr_bit,
  input  logic [SUBS-1:0]             even_bits,
  input  logic [SUBS-1:0]             odd_bits,
  output logic [PKT_BEATS-1:0]        hdr_nxt,
  output logic [SUBS*2*PKT_BEATS-1:0] body_nxt
);
  localparam int SUB_W = 2 * PKT_BEATS;

  logic [PKT_BEATS-1:0] hdr_q;

  always_comb begin
    hdr_nxt = hdr_q;
    if (shift) hdr_nxt = {hdr_bit, hdr_q[PKT_BEATS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hdr_q <= '0;
    else        hdr_q <= hdr_nxt;
  end

  for (genvar k = 0; k < SUBS; k++) begin : g_sub
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_n;

    always_comb begin
      sub_n = sub_q;
      if (shift) sub_n = {odd_bits[k], even_bits[k], sub_q[SUB_W-1:2]};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) sub_q <= '0;
      else        sub_q <= sub_n;
    end

    assign body_nxt[k*SUB_W +: SUB_W] = sub_n;
  end
endmodule

// File: rtl/isl_island_ctl.sv
module isl_island_ctl #(
  parameter int PKT_BEATS = 32,
  parameter int MAX_PKTS  = 18
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc,
  input  logic                            island_act,
  input  logic                            guard,
  output logic                            pkt_done,
  output logic                            isl_done,
  output logic [$clog2(MAX_PKTS+2)-1:0]   isl_pkts,
  output logic                            isl_err
);
  localparam int BEAT_W = $clog2(PKT_BEATS);
  localparam int CNT_W  = $clog2(MAX_PKTS + 2);
  localparam logic [CNT_W-1:0]  CNT_CAP  = CNT_W'(MAX_PKTS + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_PKTS);
  localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(PKT_BEATS - 1);

  logic [BEAT_W-1:0] beat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_isl_q;
  logic              data_beat;
  logic              close_isl;

  assign data_beat = acc && island_act && !guard;
  assign close_isl = acc && !island_act && in_isl_q;
  assign pkt_done  = data_beat && (beat_q == BEAT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q   <= '0;
      cnt_q    <= '0;
      in_isl_q <= 1'b0;
      isl_done <= 1'b0;
      isl_pkts <= '0;
      isl_err  <= 1'b0;
    end else begin
      isl_done <= close_isl;
      if (acc) in_isl_q <= island_act;
      if (close_isl) begin
        isl_pkts <= cnt_q;
        isl_err  <= (beat_q != '0) || (cnt_q == '0) || (cnt_q > CNT_MAX);
        beat_q   <= '0;
        cnt_q    <= '0;
      end else if (data_beat) begin
        beat_q <= pkt_done ? '0 : beat_q + 1'b1;
        if (pkt_done && cnt_q != CNT_CAP) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/island_pkt_asm.sv
module island_pkt_asm
  import isl_pkg::*;
#(
  parameter int PKT_BEATS = 32,
  parameter int MAX_PKTS  = 18
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic                                island_act,
  input  logic                                guard,
  input  logic [NIB_W-1:0]                    ch0,
  input  logic [NIB_W-1:0]                    ch1,
  input  logic [NIB_W-1:0]                    ch2,
  output logic                                pkt_valid,
  input  logic                                pkt_ready,
  output logic [PKT_BEATS-1:0]                pkt_hdr,
  output logic [NIB_W*2*PKT_BEATS-1:0]        pkt_body,
  output logic                                hsync,
  output logic                                vsync,
  output logic                                isl_done,
  output logic [$clog2(MAX_PKTS+2)-1:0]       isl_pkts,
  output logic                                isl_err
);
  localparam int BODY_W = NIB_W * 2 * PKT_BEATS;

  isl_beat_t            beat;
  logic                 acc;
  logic                 data_beat;
  logic                 pkt_done;
  logic [PKT_BEATS-1:0] hdr_nxt;
  logic [BODY_W-1:0]    body_nxt;

  assign in_ready  = !pkt_valid || pkt_ready;
  assign acc       = in_valid && in_ready;
  assign data_beat = acc && island_act && !guard;

  isl_beat_split u_split (
    .ch0  (ch0),
    .ch1  (ch1),
    .ch2  (ch2),
    .beat (beat)
  );

  isl_sync_rec u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (acc && island_act),
    .hs_in (beat.hs),
    .vs_in (beat.vs),
    .hsync (hsync),
    .vsync (vsync)
  );

  isl_lane_map #(.PKT_BEATS(PKT_BEATS), .SUBS(NIB_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift     (data_beat),
    .hdr_bit   (beat.hdr_bit),
    .even_bits (beat.even_bits),
    .odd_bits  (beat.odd_bits),
    .hdr_nxt   (hdr_nxt),
    .body_nxt  (body_nxt)
  );

  isl_island_ctl #(.PKT_BEATS(PKT_BEATS), .MAX_PKTS(MAX_PKTS)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .island_act (island_act),
    .guard      (guard),
    .pkt_done   (pkt_done),
    .isl_done   (isl_done),
    .isl_pkts   (isl_pkts),
    .isl_err    (isl_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_hdr   <= '0;
      pkt_body  <= '0;
    end else if (pkt_done) begin
      pkt_valid <= 1'b1;
      pkt_hdr   <= hdr_nxt;
      pkt_body  <= body_nxt;
    end else if (pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/island_pkt_asm_chk.sv
module island_pkt_asm_chk #(
  parameter int PKT_BEATS = 32,
  parameter int MAX_PKTS  = 18
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              in_valid,
  input logic                              in_ready,
  input logic                              island_act,
  input logic                              guard,
  input logic [3:0]                        ch0,
  input logic                              pkt_valid,
  input logic                              pkt_ready,
  input logic [PKT_BEATS-1:0]              pkt_hdr,
  input logic [8*PKT_BEATS-1:0]            pkt_body,
  input logic                              hsync,
  input logic                              vsync,
  input logic                              isl_done,
  input logic [$clog2(MAX_PKTS+2)-1:0]     isl_pkts,
  input logic                              isl_err
);
  a_r2_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && island_act |=> hsync == $past(ch0[0]) && vsync == $past(ch0[1]));

  a_r2_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && island_act) |=> $stable(hsync) && $stable(vsync));

  a_r5_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(in_valid && in_ready && island_act && !guard));

  a_r6_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |-> !in_ready);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_hdr) && $stable(pkt_body));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    isl_done |=> !isl_done);

  a_r9_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
    isl_done && isl_pkts == '0 |-> isl_err);

  a_r10_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    isl_done |-> isl_pkts <= ($clog2(MAX_PKTS+2))'(MAX_PKTS + 1));

  a_r10_over_err: assert property (@(posedge clk) disable iff (!rst_n)
    isl_done && isl_pkts > ($clog2(MAX_PKTS+2))'(MAX_PKTS) |-> isl_err);
endmodule

bind island_pkt_asm island_pkt_asm_chk #(.PKT_BEATS(PKT_BEATS), .MAX_PKTS(MAX_PKTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .island_act (island_act),
  .guard      (guard),
  .ch0        (ch0),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .pkt_hdr    (pkt_hdr),
  .pkt_body   (pkt_body),
  .hsync      (hsync),
  .vsync      (vsync),
  .isl_done   (isl_done),
  .isl_pkts   (isl_pkts),
  .isl_err    (isl_err)
);

// File: tb/island_pkt_asm_test.sv
module island_pkt_asm_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         island_act = 1'b0;
  logic         guard = 1'b0;
  logic [3:0]   ch0 = '0, ch1 = '0, ch2 = '0;
  logic         pkt_valid;
  logic         pkt_ready = 1'b1;
  logic [31:0]  pkt_hdr;
  logic [255:0] pkt_body;
  logic         hsync, vsync;
  logic         isl_done;
  logic [4:0]   isl_pkts;
  logic         isl_err;

  int checks = 0;
  int fails  = 0;

  logic [31:0]  q_hdr[$];
  logic [255:0] q_body[$];
  int           q_cnt[$];
  logic         q_err[$];

  logic         exp_hs = 1'b0, exp_vs = 1'b0;
  logic         sync_pend = 1'b0;
  logic         bp_mode = 1'b0;
  logic         gap_mode = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;
  int           gap_ctr = 0;
  logic         held_pend = 1'b0;
  logic [31:0]  held_hdr;
  logic [255:0] held_body;

  always #4 clk = ~clk;

  island_pkt_asm uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .island_act(island_act), .guard(guard), .ch0(ch0), .ch1(ch1), .ch2(ch2),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr),
    .pkt_body(pkt_body), .hsync(hsync), .vsync(vsync), .isl_done(isl_done),
    .isl_pkts(isl_pkts), .isl_err(isl_err)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // consumer back-pressure
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pkt_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: packets, island verdicts, sync, stall stability
  always @(negedge clk) begin
    if (rst_n) begin
      if (sync_pend) begin
        chk(hsync == exp_hs && vsync == exp_vs, "R2", "sync",
            {hsync, vsync}, {exp_hs, exp_vs});
        sync_pend = 1'b0;
      end
      if (held_pend) begin
        chk(pkt_valid && pkt_hdr == held_hdr && pkt_body == held_body, "R6",
            "stalled packet changed", {pkt_valid, pkt_hdr}, {1'b1, held_hdr});
        held_pend = 1'b0;
      end
      if (pkt_valid && !pkt_ready) begin
        chk(!in_ready, "R6", "in_ready during stall", in_ready, 0);
        held_hdr  = pkt_hdr;
        held_body = pkt_body;
        held_pend = 1'b1;
      end
      if (pkt_valid && pkt_ready) begin
        if (q_hdr.size() == 0) begin
          chk(1'b0, "R5", "unexpected packet", pkt_hdr, 0);
        end else begin
          logic [31:0]  eh;
          logic [255:0] eb;
          eh = q_hdr.pop_front();
          eb = q_body.pop_front();
          chk(pkt_hdr == eh, "R3 R5 R7", "header", pkt_hdr, eh);
          chk(pkt_body == eb, "R4 R5 R7", "body", pkt_body, eb);
        end
      end
      if (isl_done) begin
        if (q_cnt.size() == 0) begin
          chk(1'b0, "R8", "unexpected island close", isl_pkts, 0);
        end else begin
          int   ec;
          logic ee;
          ec = q_cnt.pop_front();
          ee = q_err.pop_front();
          chk(isl_pkts == 5'(ec), "R8 R10", "island count", isl_pkts, ec);
          chk(isl_err == ee, "R9 R10 R11", "island error", isl_err, ee);
        end
      end
    end
  end

  task automatic send(input logic act, input logic grd,
                      input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    in_valid = 1'b1; island_act = act; guard = grd; ch0 = a; ch1 = b; ch2 = c;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    ch0 = ~a; ch1 = ~b; ch2 = ~c;
    if (act) begin exp_hs = a[0]; exp_vs = a[1]; end
    sync_pend = 1'b1;
    gap_ctr++;
    if (gap_mode && (gap_ctr % 3 == 0)) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [1:0] sync_pat(input int n);
    return 2'(n * 7 >> 1);
  endfunction

  task automatic send_pkt(input logic record);
    logic [31:0]  h;
    logic [255:0] bd;
    h = $urandom;
    for (int k = 0; k < 8; k++) bd[k*32 +: 32] = $urandom;
    if (record) begin
      q_hdr.push_back(h);
      q_body.push_back(bd);
    end
    for (int i = 0; i < 32; i++) begin
      logic [3:0] a, b, c;
      a = {1'($urandom), h[i], sync_pat(i)};
      for (int k = 0; k < 4; k++) begin
        b[k] = bd[64*k + 2*i];
        c[k] = bd[64*k + 2*i + 1];
      end
      send(1'b1, 1'b0, a, b, c);
    end
  endtask

  task automatic run_island(input int npk, input int partial);
    int ec;
    for (int g = 0; g < 2; g++) send(1'b1, 1'b1, {2'b01, 2'(g + 1)}, 4'h5, 4'hA);
    for (int p = 0; p < npk; p++) send_pkt(1'b1);
    for (int i = 0; i < partial; i++) send(1'b1, 1'b0, 4'(i), 4'hF, 4'h0);
    for (int g = 0; g < 2; g++) send(1'b1, 1'b1, {2'b01, 2'(g)}, 4'h5, 4'hA);
    ec = (npk > 19) ? 19 : npk;
    q_cnt.push_back(ec);
    q_err.push_back(npk == 0 || npk > 18 || partial != 0);
    send(1'b0, 1'b0, 4'hF, 4'h0, 4'h0);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "R5", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!pkt_valid && !isl_done && !isl_err && !hsync && !vsync && in_ready,
        "R1", "reset state", {pkt_valid, isl_done, isl_err, hsync, vsync, in_ready},
        6'b000001);
    rst_n = 1'b1;
    @(posedge clk); #1;

    run_island(3, 0);
    // R2: beats outside an island leave the sync outputs alone
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0, 4'(i ^ 3), 4'h0, 4'h0);
    // R9: guard-only island
    run_island(0, 0);
    // R11: truncated packet, then a clean island
    run_island(2, 10);
    run_island(1, 0);
    // R6: stalls and input gaps around a full island
    bp_mode = 1'b1; gap_mode = 1'b1;
    run_island(18, 0);
    // R10: oversized island
    run_island(20, 0);
    bp_mode = 1'b0; gap_mode = 1'b0;

    repeat (20) @(posedge clk);
    #1;
    chk(q_hdr.size() == 0, "R5", "packets outstanding", q_hdr.size(), 0);
    chk(q_cnt.size() == 0, "R8", "islands outstanding", q_cnt.size(), 0);
    summary();
    $finish;
  end
endmodule